// File: doc/BRIEF.md
# Two-Wire Slave Address Matcher

This block is the slave half of a two-wire serial controller. It watches the clock and data lines, which are sampled on the system clock, and detects Start and Stop conditions. After each Start it shifts in the eight-bit address byte and compares the upper seven bits with two own addresses. Each own address has its own enable. When general-call matching is enabled, the all-zero general-call address is also accepted. On a hit it acknowledges the byte, records which address matched, raises a new-match flag and reports the direction the master requested. A match with the new-match interrupt enabled raises an interrupt.

Once addressed, the block moves bytes in either direction. After every byte it acknowledges, it holds the clock line low. The clock is freed when the host reads or writes the data register through single-cycle strobes. In slave transmit the host's write supplies the next byte, and the byte goes out most significant bit first. A NACK from the master ends the transmission. A Stop returns the block to idle. Deasserting the enable releases both lines and clears all status.

Top module: `twi_slave_matcher`

## Requirements
- R1: After the eighth address bit following a Start, a 7-bit address equal to `own_addr1_i` matches only while `own_en1_i` is 1. A match sets `match_o`, `addr_hit_o[0]` and `new_match_o`, and drives `sda_oe_o` high for the acknowledge bit.
- R2: Own address 2 (`own_addr2_i`, `own_en2_i`) behaves the same way and sets `addr_hit_o[1]`. An equal but disabled own address 1 does not set `addr_hit_o[0]`.
- R3: Address 0000000 matches only while `gc_en_i` is 1. Such a match sets `gc_match_o`, `match_o` and `new_match_o`, and acknowledges the byte.
- R4: An address that matches nothing gets no acknowledge and sets no flag. The block then ignores the bus until the next Start.
- R5: The eighth address bit selects the direction, with 1 meaning the master reads. On a match with that bit at 1, `xmit_o` and `buf_empty_o` go high. With that bit at 0 both stay low.
- R6: `irq_o` is high only while `int_en_i`, `nm_int_en_i` and `new_match_o` are all high.
- R7: A `clr_nmatch_i` strobe clears `new_match_o`, and therefore `irq_o`, and leaves `match_o` unchanged.
- R8: After each byte it acknowledges, and after each byte it transmits that the master acknowledges, the block drives `scl_oe_o` high on the falling clock edge that ends the byte. `scl_oe_o` stays high until a `rd_strobe_i` or `wr_strobe_i` arrives. In the waiting state after a transmitted byte, only `wr_strobe_i` releases it.
- R9: In receive mode each data byte, taken most significant bit first, appears on `rd_data_o` and is acknowledged.
- R10: In transmit mode the byte given with `wr_strobe_i` is sent most significant bit first, with `sda_oe_o` equal to the inverse of each bit. The write clears `buf_empty_o`. A master ACK after the byte sets `buf_empty_o` again.
- R11: A master NACK after a transmitted byte makes the block release SDA and SCL. It drives neither line until the next Start.
- R12: A Stop returns the block to idle, releases both lines and clears `match_o`, `addr_hit_o`, `gc_match_o`, `xmit_o` and `buf_empty_o`. The same values hold after reset.
- R13: While `en_i` is 0, both lines are released and all flags are clear. Bus traffic in that time gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| own_addr1_i | input | 7 | Own address 1 |
| own_en1_i | input | 1 | Enable for own address 1 |
| own_addr2_i | input | 7 | Own address 2 |
| own_en2_i | input | 1 | Enable for own address 2 |
| gc_en_i | input | 1 | General-call match enable |
| int_en_i | input | 1 | Global interrupt enable |
| nm_int_en_i | input | 1 | New-match interrupt enable |
| scl_i | input | 1 | Sampled clock line |
| sda_i | input | 1 | Sampled data line |
| scl_oe_o | output | 1 | Pull clock line low (stretch) |
| sda_oe_o | output | 1 | Pull data line low |
| rd_strobe_i | input | 1 | Host data read strobe |
| wr_strobe_i | input | 1 | Host data write strobe |
| wr_data_i | input | 8 | Byte to transmit |
| clr_nmatch_i | input | 1 | Clear new-match flag strobe |
| rd_data_o | output | 8 | Last received data byte |
| match_o | output | 1 | Addressed since the last Start |
| addr_hit_o | output | 2 | Own address that matched: bit 0 is address 1, bit 1 is address 2 |
| gc_match_o | output | 1 | General-call match |
| new_match_o | output | 1 | Match not yet cleared by the host |
| xmit_o | output | 1 | Slave transmit direction |
| buf_empty_o | output | 1 | Transmit byte needed |
| irq_o | output | 1 | Interrupt request |

## Verification
Every line and flag result is registered on the system-clock edge that first sees the triggering SCL or SDA change. A host strobe has its effect on the edge where the strobe is sampled. Either way the result is visible one clock later. The bench moves SCL and SDA on falling system-clock edges and holds each bus level for four clocks. It therefore reads the acknowledge, stretch and flag outputs at least three clocks after the edge that produced them, while the bus is still stable. It reads the outputs after a host strobe two clocks after the strobe. Transmitted bits are read from the wired data line in the middle of each high clock phase.

// File: rtl/twi_slv_pkg.sv
package twi_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_RX,
    ST_TX,
    ST_TX_ACK,
    ST_TX_WAIT
  } slv_state_e;
endpackage

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SDA moves while SCL stays high
  assign start_o = scl_i && scl_q && sda_q && !sda_i;
  assign stop_o  = scl_i && scl_q && !sda_q && sda_i;
  assign rise_o  = scl_i && !scl_q;
  assign fall_o  = !scl_i && scl_q;
endmodule

// File: rtl/twi_addr_compare.sv
module twi_addr_compare #(
  parameter int unsigned AW = 7,
  parameter int unsigned N  = 2
) (
  input  logic [AW-1:0]        addr_i,
  input  logic [N-1:0][AW-1:0] own_addr_i,
  input  logic [N-1:0]         own_en_i,
  input  logic                 gc_en_i,
  output logic [N-1:0]         own_hit_o,
  output logic                 gc_hit_o,
  output logic                 any_o
);
  for (genvar i = 0; i < N; i++) begin : g_own
    assign own_hit_o[i] = own_en_i[i] && (addr_i == own_addr_i[i]);
  end

  assign gc_hit_o = gc_en_i && (addr_i == '0);
  assign any_o    = gc_hit_o || (|own_hit_o);
endmodule

// File: rtl/twi_slave_matcher.sv
module twi_slave_matcher
  import twi_slv_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-2:0] own_addr1_i,
  input  logic          own_en1_i,
  input  logic [DW-2:0] own_addr2_i,
  input  logic          own_en2_i,
  input  logic          gc_en_i,
  input  logic          int_en_i,
  input  logic          nm_int_en_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  input  logic          rd_strobe_i,
  input  logic          wr_strobe_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          clr_nmatch_i,
  output logic [DW-1:0] rd_data_o,
  output logic          match_o,
  output logic [1:0]    addr_hit_o,
  output logic          gc_match_o,
  output logic          new_match_o,
  output logic          xmit_o,
  output logic          buf_empty_o,
  output logic          irq_o
);
  localparam int unsigned AW = DW - 1;
  localparam int unsigned CW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DW);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic start, stop, rise, fall;
  logic [1:0] own_hit;
  logic gc_hit, any_hit;

  slv_state_e    st_q;
  logic [DW-1:0] sh_q, rx_q;
  logic [CW-1:0] cnt_q;
  logic          hold_q, sda_low_q;
  logic          match_q, gc_q, nm_q, xmit_q, bufe_q;
  logic [1:0]    hit_q;

  twi_bus_events u_evt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .start_o (start),
    .stop_o  (stop),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  twi_addr_compare #(.AW(AW), .N(2)) u_cmp (
    .addr_i     (sh_q[DW-1:1]),
    .own_addr_i ({own_addr2_i, own_addr1_i}),
    .own_en_i   ({own_en2_i, own_en1_i}),
    .gc_en_i    (gc_en_i),
    .own_hit_o  (own_hit),
    .gc_hit_o   (gc_hit),
    .any_o      (any_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      sh_q      <= '0;
      rx_q      <= '0;
      cnt_q     <= '0;
      hold_q    <= 1'b0;
      sda_low_q <= 1'b0;
      match_q   <= 1'b0;
      hit_q     <= '0;
      gc_q      <= 1'b0;
      nm_q      <= 1'b0;
      xmit_q    <= 1'b0;
      bufe_q    <= 1'b0;
    end else if (!en_i) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      hold_q    <= 1'b0;
      sda_low_q <= 1'b0;
      match_q   <= 1'b0;
      hit_q     <= '0;
      gc_q      <= 1'b0;
      nm_q      <= 1'b0;
      xmit_q    <= 1'b0;
      bufe_q    <= 1'b0;
    end else begin
      if (stop || start) begin
        st_q      <= stop ? ST_IDLE : ST_ADDR;
        cnt_q     <= '0;
        hold_q    <= 1'b0;
        sda_low_q <= 1'b0;
        match_q   <= 1'b0;
        hit_q     <= '0;
        gc_q      <= 1'b0;
        xmit_q    <= 1'b0;
        bufe_q    <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (rise) begin
              sh_q  <= {sh_q[DW-2:0], sda_i};
              cnt_q <= cnt_q + CNT_ONE;
            end else if (fall && cnt_q == CNT_FULL) begin
              if (any_hit) begin
                st_q      <= ST_ACK;
                sda_low_q <= 1'b1;
                hold_q    <= 1'b1;
                match_q   <= 1'b1;
                nm_q      <= 1'b1;
                hit_q     <= own_hit;
                gc_q      <= gc_hit;
                xmit_q    <= sh_q[0];
                bufe_q    <= sh_q[0];
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (hold_q) begin
              if (wr_strobe_i) begin
                sh_q   <= wr_data_i;
                bufe_q <= 1'b0;
                hold_q <= 1'b0;
              end else if (rd_strobe_i) begin
                hold_q <= 1'b0;
              end
            end else if (fall) begin
              cnt_q <= '0;
              if (xmit_q) begin
                st_q      <= ST_TX;
                sda_low_q <= ~sh_q[DW-1];
              end else begin
                st_q      <= ST_RX;
                sda_low_q <= 1'b0;
              end
            end
          end
          ST_RX: begin
            if (rise) begin
              sh_q  <= {sh_q[DW-2:0], sda_i};
              cnt_q <= cnt_q + CNT_ONE;
            end else if (fall && cnt_q == CNT_FULL) begin
              rx_q      <= sh_q;
              sda_low_q <= 1'b1;
              hold_q    <= 1'b1;
              st_q      <= ST_ACK;
            end
          end
          ST_TX: begin
            if (rise) begin
              cnt_q <= cnt_q + CNT_ONE;
            end else if (fall) begin
              if (cnt_q == CNT_FULL) begin
                sda_low_q <= 1'b0;
                st_q      <= ST_TX_ACK;
              end else begin
                sh_q      <= {sh_q[DW-2:0], 1'b0};
                sda_low_q <= ~sh_q[DW-2];
              end
            end
          end
          ST_TX_ACK: begin
            if (rise && sda_i) begin
              st_q <= ST_IDLE;  // master NACK: bus left alone until next Start
            end else if (fall) begin
              hold_q <= 1'b1;
              bufe_q <= 1'b1;
              st_q   <= ST_TX_WAIT;
            end
          end
          ST_TX_WAIT: begin
            if (wr_strobe_i) begin
              sh_q      <= wr_data_i;
              sda_low_q <= ~wr_data_i[DW-1];
              cnt_q     <= '0;
              hold_q    <= 1'b0;
              bufe_q    <= 1'b0;
              st_q      <= ST_TX;
            end
          end
          default: ;
        endcase
      end
      if (clr_nmatch_i) nm_q <= 1'b0;  // host clear wins over a same-cycle match
    end
  end

  assign scl_oe_o    = hold_q;
  assign sda_oe_o    = sda_low_q;
  assign rd_data_o   = rx_q;
  assign match_o     = match_q;
  assign addr_hit_o  = hit_q;
  assign gc_match_o  = gc_q;
  assign new_match_o = nm_q;
  assign xmit_o      = xmit_q;
  assign buf_empty_o = bufe_q;
  assign irq_o       = int_en_i && nm_int_en_i && nm_q;
endmodule

// File: rtl/twi_slave_matcher_chk.sv
module twi_slave_matcher_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          int_en_i,
  input logic          nm_int_en_i,
  input logic          scl_i,
  input logic          sda_i,
  input logic          scl_oe_o,
  input logic          sda_oe_o,
  input logic          rd_strobe_i,
  input logic          wr_strobe_i,
  input logic          clr_nmatch_i,
  input logic          match_o,
  input logic          new_match_o,
  input logic          xmit_o,
  input logic          buf_empty_o,
  input logic          irq_o
);
  // R8
  stretch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o && en_i && !rd_strobe_i && !wr_strobe_i |=> scl_oe_o);

  // R13
  disable_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !scl_oe_o && !sda_oe_o && !match_o && !new_match_o);

  // R4
  ack_needs_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> match_o);

  // R5
  xmit_needs_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xmit_o |-> match_o);

  // R5
  buf_empty_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_empty_o |-> xmit_o);

  // R7
  nmatch_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_nmatch_i |=> !new_match_o);

  // R6
  irq_on_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(new_match_o) && int_en_i && nm_int_en_i |-> irq_o);

  // R12
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_i && $past(scl_i) && sda_i && !$past(sda_i) |=> !match_o && !xmit_o && !scl_oe_o);
endmodule

bind twi_slave_matcher twi_slave_matcher_chk #(.DW(DW)) u_chk (.*);

// File: tb/twi_slave_matcher_test.sv
module twi_slave_matcher_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       en, own_en1, own_en2, gc_en, int_en, nm_int_en;
  logic [6:0] own_addr1, own_addr2;
  logic       scl_m, sda_m, scl_bus, sda_bus;
  logic       scl_oe, sda_oe, rd_stb, wr_stb, clr_nm;
  logic [7:0] wr_data, rd_data;
  logic       match, gc_match, new_match, xmit, buf_empty, irq;
  logic [1:0] addr_hit;

  int n_chk = 0;
  int n_err = 0;

  assign scl_bus = scl_m & ~scl_oe;
  assign sda_bus = sda_m & ~sda_oe;

  twi_slave_matcher uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .en_i         (en),
    .own_addr1_i  (own_addr1),
    .own_en1_i    (own_en1),
    .own_addr2_i  (own_addr2),
    .own_en2_i    (own_en2),
    .gc_en_i      (gc_en),
    .int_en_i     (int_en),
    .nm_int_en_i  (nm_int_en),
    .scl_i        (scl_bus),
    .sda_i        (sda_bus),
    .scl_oe_o     (scl_oe),
    .sda_oe_o     (sda_oe),
    .rd_strobe_i  (rd_stb),
    .wr_strobe_i  (wr_stb),
    .wr_data_i    (wr_data),
    .clr_nmatch_i (clr_nm),
    .rd_data_o    (rd_data),
    .match_o      (match),
    .addr_hit_o   (addr_hit),
    .gc_match_o   (gc_match),
    .new_match_o  (new_match),
    .xmit_o       (xmit),
    .buf_empty_o  (buf_empty),
    .irq_o        (irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(2);
    scl_m = 1'b1; tick(4);
    sda_m = 1'b0; tick(4);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(4);
    scl_m = 1'b1; tick(4);
    sda_m = 1'b1; tick(4);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b;    tick(4);
    scl_m = 1'b1; tick(4);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(2);
    b = sda_bus;  tick(2);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic byte_out(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic byte_in(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
  endtask

  task automatic host_rd();
    rd_stb = 1'b1; tick(1);
    rd_stb = 1'b0; tick(2);
  endtask

  task automatic host_wr(input logic [7:0] d);
    wr_data = d; wr_stb = 1'b1; tick(1);
    wr_stb = 1'b0; tick(2);
  endtask

  task automatic host_clr();
    clr_nm = 1'b1; tick(1);
    clr_nm = 1'b0; tick(2);
  endtask

  task automatic t_reset();
    chk("R12 reset scl_oe", scl_oe, 0);
    chk("R12 reset sda_oe", sda_oe, 0);
    chk("R12 reset match", match, 0);
    chk("R12 reset xmit", xmit, 0);
    chk("R6 reset irq", irq, 0);
  endtask

  task automatic t_own1_rx();
    logic b;
    own_addr1 = 7'h3A; own_en1 = 1'b1; own_en2 = 1'b0; gc_en = 1'b0;
    int_en = 1'b1; nm_int_en = 1'b1;
    bus_start();
    byte_out({7'h3A, 1'b0});
    chk("R1 ack driven", sda_oe, 1);
    chk("R1 match", match, 1);
    chk("R1 addr_hit", addr_hit, 2'b01);
    chk("R1 new_match", new_match, 1);
    chk("R5 write dir xmit", xmit, 0);
    chk("R5 write dir buf_empty", buf_empty, 0);
    chk("R6 irq both enabled", irq, 1);
    chk("R8 stretch after address", scl_oe, 1);
    tick(20);
    chk("R8 stretch held", scl_oe, 1);
    host_clr();
    chk("R7 new_match cleared", new_match, 0);
    chk("R7 match kept", match, 1);
    chk("R6 irq after clear", irq, 0);
    host_rd();
    chk("R8 released by read", scl_oe, 0);
    bit_in(b);
    chk("R1 ack seen on bus", b, 0);
    chk("R9 sda released after ack", sda_oe, 0);
    byte_out(8'hC5);
    chk("R9 rx byte 1", rd_data, 8'hC5);
    chk("R9 data ack", sda_oe, 1);
    chk("R8 stretch after data", scl_oe, 1);
    host_rd();
    bit_in(b);
    chk("R9 data ack on bus", b, 0);
    byte_out(8'h5A);
    chk("R9 rx byte 2", rd_data, 8'h5A);
    host_rd();
    bit_in(b);
    bus_stop();
    chk("R12 stop match", match, 0);
    chk("R12 stop addr_hit", addr_hit, 0);
    chk("R12 stop lines", {scl_oe, sda_oe}, 2'b00);
  endtask

  task automatic t_own2_tx();
    logic b;
    logic [7:0] v;
    own_addr1 = 7'h51; own_en1 = 1'b0; own_addr2 = 7'h51; own_en2 = 1'b1;
    bus_start();
    byte_out({7'h51, 1'b1});
    chk("R2 addr_hit", addr_hit, 2'b10);
    chk("R2 ack driven", sda_oe, 1);
    chk("R5 read dir xmit", xmit, 1);
    chk("R5 read dir buf_empty", buf_empty, 1);
    host_wr(8'hA6);
    chk("R10 buf_empty cleared by write", buf_empty, 0);
    chk("R8 released by write", scl_oe, 0);
    bit_in(b);
    chk("R2 ack on bus", b, 0);
    byte_in(v);
    chk("R10 tx byte 1", v, 8'hA6);
    bit_out(1'b0);
    chk("R10 stretch after master ack", scl_oe, 1);
    chk("R10 buf_empty after master ack", buf_empty, 1);
    tick(6);
    chk("R8 stretch held in tx wait", scl_oe, 1);
    host_wr(8'h3C);
    byte_in(v);
    chk("R10 tx byte 2", v, 8'h3C);
    bit_out(1'b1);
    chk("R11 sda released after nack", sda_oe, 0);
    chk("R11 scl released after nack", scl_oe, 0);
    byte_in(v);
    chk("R11 bus untouched after nack", v, 8'hFF);
    bit_in(b);
    chk("R11 no stretch after nack", scl_oe, 0);
    bus_stop();
    chk("R12 stop clears xmit", xmit, 0);
    chk("R12 stop clears buf_empty", buf_empty, 0);
  endtask

  task automatic t_gcall();
    logic b;
    own_addr1 = 7'h3A; own_en1 = 1'b1; own_en2 = 1'b0; gc_en = 1'b0;
    bus_start();
    byte_out(8'h00);
    chk("R3 gc disabled no ack", sda_oe, 0);
    chk("R3 gc disabled no match", match, 0);
    bus_stop();
    gc_en = 1'b1;
    bus_start();
    byte_out(8'h00);
    chk("R3 gc flag", gc_match, 1);
    chk("R3 gc match", match, 1);
    chk("R3 gc addr_hit", addr_hit, 2'b00);
    chk("R3 gc ack", sda_oe, 1);
    chk("R3 gc new_match", new_match, 1);
    host_clr();
    host_rd();
    bit_in(b);
    bus_stop();
    chk("R12 stop clears gc", gc_match, 0);
    gc_en = 1'b0;
  endtask

  task automatic t_nomatch();
    logic b;
    bus_start();
    byte_out({7'h12, 1'b0});
    chk("R4 no ack", sda_oe, 0);
    chk("R4 no match", match, 0);
    chk("R4 no new_match", new_match, 0);
    chk("R4 no stretch", scl_oe, 0);
    bit_in(b);
    chk("R4 nack on bus", b, 1);
    byte_out({7'h3A, 1'b0});
    chk("R4 ignored until start", sda_oe, 0);
    chk("R4 ignored match", match, 0);
    bus_stop();
  endtask

  task automatic t_irq_gate();
    logic b;
    int_en = 1'b1; nm_int_en = 1'b0;
    bus_start();
    byte_out({7'h3A, 1'b0});
    chk("R6 new_match set", new_match, 1);
    chk("R6 irq masked by nm enable", irq, 0);
    nm_int_en = 1'b1; tick(1);
    chk("R6 irq both enables", irq, 1);
    int_en = 1'b0; tick(1);
    chk("R6 irq masked by global", irq, 0);
    int_en = 1'b1;
    host_clr();
    host_rd();
    bit_in(b);
    bus_stop();
  endtask

  task automatic t_disable();
    bus_start();
    byte_out({7'h3A, 1'b0});
    chk("R13 setup stretch", scl_oe, 1);
    en = 1'b0; tick(2);
    chk("R13 lines released", {scl_oe, sda_oe}, 2'b00);
    chk("R13 flags cleared", {match, new_match, addr_hit}, 4'b0000);
    bus_start();
    byte_out({7'h3A, 1'b0});
    chk("R13 no ack while disabled", sda_oe, 0);
    chk("R13 no match while disabled", match, 0);
    en = 1'b1;
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    en = 1'b1; own_en1 = 1'b0; own_en2 = 1'b0; gc_en = 1'b0;
    int_en = 1'b0; nm_int_en = 1'b0;
    own_addr1 = '0; own_addr2 = '0;
    scl_m = 1'b1; sda_m = 1'b1;
    rd_stb = 1'b0; wr_stb = 1'b0; clr_nm = 1'b0; wr_data = '0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_own1_rx();
    t_own2_tx();
    t_gcall();
    t_nomatch();
    t_irq_gate();
    t_disable();
    summary();
    $finish;
  end
endmodule